// File: doc/BRIEF.md
# Class-Ordered Reply Completion Scheduler

This block lives inside a system controller and decides which outstanding processor transactions of one request class may be sent a completion reply. Each issued transaction is written into a small age-ordered tracking queue with its tag and a type code. A memory or I/O model later reports, by tag, that the transaction's work is done. The scheduler then grants at most one completion per clock. It respects the ordering each data buffer needs, and otherwise lets work finish as soon as it is ready.

Ordering is enforced only inside each data-buffer family. Sixteen-byte noncacheable loads and stores form one in-order family, so a load can never overtake an older store. Block stores and coherent block writes form a second in-order family. Writebacks have no ordering constraint and may pass anything older. Among several eligible entries, the oldest one wins. A granted entry leaves the queue in the same cycle, so its slot can be refilled on the next clock.

Top module: `cls_reply_sched`

## Requirements
- R1: While reset is active, and on the first cycles after it, the queue is empty, `gnt_vld` is 0 and all three error outputs are 0.
- R2: `gnt_vld` is asserted only for an entry that is held and marked ready. `gnt_tag` and `gnt_ty` carry that entry's tag and type code. There is at most one grant per cycle.
- R3: Type codes 0 (noncacheable 16-byte load) and 1 (noncacheable 16-byte store) form one family. An entry of this family is granted only when no older entry of the same family is held. As a result, stores complete in issue order and a load waits for every older store.
- R4: Type codes 2 (64-byte block store) and 3 (coherent block write) form a second family. An entry of this family is granted only when no older entry of that family is held.
- R5: A ready entry of type code 4 (writeback) is eligible regardless of any older entry. Whenever one is held and ready, a grant is made in that cycle.
- R6: When several entries are eligible in the same cycle, the oldest by issue order is granted.
- R7: A granted entry is removed in the cycle of its grant and is never granted again. Up to DEPTH (8) entries can be held at once.
- R8: An issue of a legal type while DEPTH entries are held at the start of the cycle is dropped. `err_overflow` is 1 for exactly the following cycle. This applies even when a grant happens in the same cycle.
- R9: An issue of type code 1 while a type code 0 entry is held (and not granted in that cycle) is still accepted. `err_order` is 1 for exactly the following cycle.
- R10: An issue with type code 5, 6 or 7 is dropped and raises `err_type` for exactly the following cycle. A later ready event for its tag produces no grant.
- R11: A ready event (`rdy_vld` with `rdy_tag`) marks every held entry with that tag as ready, effective from the next cycle. It also marks an entry issued with the same tag in the same cycle. A ready event for a tag that is not held has no effect, even on a later issue of that tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| iss_vld | input | 1 | Issue of a new transaction this cycle |
| iss_tag | input | TAG_W (4) | Tag of the issued transaction |
| iss_ty | input | 3 | Type code of the issued transaction (0..4 legal) |
| rdy_vld | input | 1 | Ready-to-complete event this cycle |
| rdy_tag | input | TAG_W (4) | Tag reported ready |
| gnt_vld | output | 1 | Completion grant this cycle |
| gnt_tag | output | TAG_W (4) | Tag of the granted entry |
| gnt_ty | output | 3 | Type code of the granted entry |
| err_overflow | output | 1 | One-cycle pulse: previous issue dropped because the queue was full |
| err_order | output | 1 | One-cycle pulse: previous store issued behind a held load |
| err_type | output | 1 | One-cycle pulse: previous issue had an illegal type code |

## Verification
Some properties are checked by assertions on every cycle, against the internal queue contents. These are: a grant always points at a held, ready entry; neither in-order family ever grants past an older member; a ready writeback always produces a grant; the occupancy never exceeds the depth and drops by one on a grant without an issue; and the error pulses follow a full-queue or illegal-type issue. Some behaviours only show up in the bench's scenarios, compared against its behavioural queue model. These are which entry wins when several become eligible together, how ready events arriving out of issue order are held until their family unblocks, the exact grant sequence of a refilled queue, and the fact that a stray ready event leaves a later issue unready.

// File: rtl/cls_sched_pkg.sv
package cls_sched_pkg;

  localparam int TY_W = 3;

  typedef enum logic [TY_W-1:0] {
    TY_NCLD  = 3'd0,
    TY_NCST  = 3'd1,
    TY_BLKST = 3'd2,
    TY_COHWR = 3'd3,
    TY_WRBK  = 3'd4
  } txn_ty_e;

  function automatic logic ty_legal(input logic [TY_W-1:0] t);
    return t <= TY_WRBK;
  endfunction

  function automatic logic ty_small(input logic [TY_W-1:0] t);
    return (t == TY_NCLD) || (t == TY_NCST);
  endfunction

  function automatic logic ty_block(input logic [TY_W-1:0] t);
    return (t == TY_BLKST) || (t == TY_COHWR);
  endfunction

endpackage

// File: rtl/cls_sched_queue.sv
module cls_sched_queue
  import cls_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic [TY_W-1:0]             push_ty,
  input  logic                        mark,
  input  logic [TAG_W-1:0]            mark_tag,
  input  logic                        pop,
  input  logic [IDX_W-1:0]            pop_idx,
  output logic [DEPTH-1:0]            ent_vld,
  output logic [DEPTH-1:0]            ent_rdy,
  output logic [DEPTH-1:0][TAG_W-1:0] ent_tag,
  output logic [DEPTH-1:0][TY_W-1:0]  ent_ty,
  output logic [CNT_W-1:0]            count
);

  logic [DEPTH-1:0]            vld_q, vld_n;
  logic [DEPTH-1:0]            rdy_q, rdy_n;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_n;
  logic [DEPTH-1:0][TY_W-1:0]  ty_q, ty_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n;
  logic [CNT_W-1:0]            wr_pos;
  logic                        data_en;

  assign wr_pos  = cnt_q - CNT_W'(pop);
  assign data_en = push | pop;

  // Next state: close the gap left by a grant, apply ready marks, append.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (pop && (i >= int'(pop_idx))) ? i + 1 : i;
      if (src < DEPTH) begin
        vld_n[i] = vld_q[src];
        rdy_n[i] = rdy_q[src];
        tag_n[i] = tag_q[src];
        ty_n[i]  = ty_q[src];
      end else begin
        vld_n[i] = 1'b0;
        rdy_n[i] = 1'b0;
        tag_n[i] = '0;
        ty_n[i]  = '0;
      end
      if (mark && vld_n[i] && (tag_n[i] == mark_tag)) begin
        rdy_n[i] = 1'b1;
      end
      if (push && (CNT_W'(i) == wr_pos)) begin
        vld_n[i] = 1'b1;
        rdy_n[i] = mark && (mark_tag == push_tag);
        tag_n[i] = push_tag;
        ty_n[i]  = push_ty;
      end
    end
    cnt_n = cnt_q - CNT_W'(pop) + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rdy_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_n;
      rdy_q <= rdy_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      tag_q <= tag_n;
      ty_q  <= ty_n;
    end
  end

  assign ent_vld = vld_q;
  assign ent_rdy = rdy_q;
  assign ent_tag = tag_q;
  assign ent_ty  = ty_q;
  assign count   = cnt_q;

endmodule

// File: rtl/cls_sched_elig.sv
module cls_sched_elig
  import cls_sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]           ent_vld,
  input  logic [DEPTH-1:0]           ent_rdy,
  input  logic [DEPTH-1:0][TY_W-1:0] ent_ty,
  output logic [DEPTH-1:0]           elig
);

  logic [DEPTH-1:0] small_v;
  logic [DEPTH-1:0] block_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_class
    assign small_v[i] = ent_vld[i] && ty_small(ent_ty[i]);
    assign block_v[i] = ent_vld[i] && ty_block(ent_ty[i]);
  end

  // Slot 0 is oldest; an entry is blocked by any older held member of its family.
  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    localparam logic [DEPTH-1:0] OLDER = (DEPTH'(1) << i) - DEPTH'(1);
    logic blocked;
    assign blocked = small_v[i] ? |(small_v & OLDER) :
                     block_v[i] ? |(block_v & OLDER) : 1'b0;
    assign elig[i] = ent_vld[i] && ent_rdy[i] && !blocked;
  end

endmodule

// File: rtl/cls_sched_arb.sv
module cls_sched_arb #(
  parameter int DEPTH = 8,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);

  always_comb begin
    gnt_vld = |req;
    gnt_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/cls_reply_sched.sv
module cls_reply_sched
  import cls_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [2:0]       iss_ty,
  input  logic             rdy_vld,
  input  logic [TAG_W-1:0] rdy_tag,
  output logic             gnt_vld,
  output logic [TAG_W-1:0] gnt_tag,
  output logic [2:0]       gnt_ty,
  output logic             err_overflow,
  output logic             err_order,
  output logic             err_type
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]                  rst_sync_q;
  logic                        rst_sync_n;
  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0]            ent_rdy;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic [DEPTH-1:0][TY_W-1:0]  ent_ty;
  logic [CNT_W-1:0]            q_count;
  logic [DEPTH-1:0]            elig;
  logic                        arb_vld;
  logic [IDX_W-1:0]            arb_idx;
  logic                        q_full;
  logic                        iss_ok_ty;
  logic                        push;
  logic                        load_held;
  logic                        ovf_n, ord_n, typ_n;
  logic                        ovf_q, ord_q, typ_q;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign q_full    = (q_count == CNT_W'(DEPTH));
  assign iss_ok_ty = ty_legal(iss_ty);
  assign push      = iss_vld && iss_ok_ty && !q_full;

  cls_sched_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (push),
    .push_tag (iss_tag),
    .push_ty  (iss_ty),
    .mark     (rdy_vld),
    .mark_tag (rdy_tag),
    .pop      (arb_vld),
    .pop_idx  (arb_idx),
    .ent_vld  (ent_vld),
    .ent_rdy  (ent_rdy),
    .ent_tag  (ent_tag),
    .ent_ty   (ent_ty),
    .count    (q_count)
  );

  cls_sched_elig #(.DEPTH(DEPTH)) u_elig (
    .ent_vld (ent_vld),
    .ent_rdy (ent_rdy),
    .ent_ty  (ent_ty),
    .elig    (elig)
  );

  cls_sched_arb #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_arb (
    .req     (elig),
    .gnt_vld (arb_vld),
    .gnt_idx (arb_idx)
  );

  // A load leaving in this very cycle no longer counts as held.
  always_comb begin
    load_held = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && (ent_ty[i] == TY_NCLD) &&
          !(arb_vld && (arb_idx == IDX_W'(i)))) begin
        load_held = 1'b1;
      end
    end
  end

  always_comb begin
    ovf_n = iss_vld && iss_ok_ty && q_full;
    ord_n = push && (iss_ty == TY_NCST) && load_held;
    typ_n = iss_vld && !iss_ok_ty;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_q <= 1'b0;
      ord_q <= 1'b0;
      typ_q <= 1'b0;
    end else begin
      ovf_q <= ovf_n;
      ord_q <= ord_n;
      typ_q <= typ_n;
    end
  end

  assign gnt_vld      = arb_vld;
  assign gnt_tag      = ent_tag[arb_idx];
  assign gnt_ty       = ent_ty[arb_idx];
  assign err_overflow = ovf_q;
  assign err_order    = ord_q;
  assign err_type     = typ_q;

endmodule

// File: rtl/cls_reply_sched_chk.sv
module cls_reply_sched_chk
  import cls_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       iss_vld,
  input logic [2:0]                 iss_ty,
  input logic                       gnt_vld,
  input logic [2:0]                 gnt_ty,
  input logic                       err_overflow,
  input logic                       err_type,
  input logic [DEPTH-1:0]           ent_vld,
  input logic [DEPTH-1:0]           ent_rdy,
  input logic [DEPTH-1:0][TY_W-1:0] ent_ty,
  input logic [IDX_W-1:0]           gnt_idx,
  input logic [CNT_W-1:0]           count
);

  function automatic logic older_same(input logic [DEPTH-1:0] v,
                                      input logic [DEPTH-1:0][TY_W-1:0] t,
                                      input int idx, input logic blk);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j < idx && v[j] && (blk ? ty_block(t[j]) : ty_small(t[j]))) hit = 1'b1;
    end
    return hit;
  endfunction

  logic wb_ready;
  always_comb begin
    wb_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && ent_rdy[i] && (ent_ty[i] == TY_WRBK)) wb_ready = 1'b1;
    end
  end

  assert_gnt_ready_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gnt_vld |-> (ent_vld[gnt_idx] && ent_rdy[gnt_idx]));

  assert_small_order_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_vld && ty_small(gnt_ty)) |-> !older_same(ent_vld, ent_ty, int'(gnt_idx), 1'b0));

  assert_block_order_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_vld && ty_block(gnt_ty)) |-> !older_same(ent_vld, ent_ty, int'(gnt_idx), 1'b1));

  assert_wb_progress_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_ready |-> gnt_vld);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_vld && !iss_vld) |=> (count == CNT_W'($past(count) - 1'b1)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    count <= CNT_W'(DEPTH));

  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_vld && ty_legal(iss_ty) && (count == CNT_W'(DEPTH))) |=> err_overflow);

  assert_type_flag_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_vld && !ty_legal(iss_ty)) |=> (err_type && !err_overflow));

endmodule

bind cls_reply_sched cls_reply_sched_chk #(
  .DEPTH (DEPTH),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .iss_vld      (iss_vld),
  .iss_ty       (iss_ty),
  .gnt_vld      (gnt_vld),
  .gnt_ty       (gnt_ty),
  .err_overflow (err_overflow),
  .err_type     (err_type),
  .ent_vld      (ent_vld),
  .ent_rdy      (ent_rdy),
  .ent_ty       (ent_ty),
  .gnt_idx      (arb_idx),
  .count        (q_count)
);

// File: tb/cls_reply_sched_bench.sv
module cls_reply_sched_bench;

  localparam int DEPTH = 8;

  logic       clk;
  logic       rst_n;
  logic       iss_vld;
  logic [3:0] iss_tag;
  logic [2:0] iss_ty;
  logic       rdy_vld;
  logic [3:0] rdy_tag;
  logic       gnt_vld;
  logic [3:0] gnt_tag;
  logic [2:0] gnt_ty;
  logic       err_overflow;
  logic       err_order;
  logic       err_type;

  cls_reply_sched #(.DEPTH(DEPTH), .TAG_W(4)) u_cls_reply_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_vld      (iss_vld),
    .iss_tag      (iss_tag),
    .iss_ty       (iss_ty),
    .rdy_vld      (rdy_vld),
    .rdy_tag      (rdy_tag),
    .gnt_vld      (gnt_vld),
    .gnt_tag      (gnt_tag),
    .gnt_ty       (gnt_ty),
    .err_overflow (err_overflow),
    .err_order    (err_order),
    .err_type     (err_type)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [3:0] tag;
    logic [2:0] ty;
    bit         rdy;
  } ment_t;

  ment_t mq[$];
  bit    e_ovf, e_ord, e_typ;
  int    n_cmp, n_bad, cycles;
  bit    done;
  string cur_req;

  function automatic int fam(input logic [2:0] t);
    if (t == 3'd0 || t == 3'd1) return 0;
    if (t == 3'd2 || t == 3'd3) return 1;
    return 2;
  endfunction

  // Oldest ready entry with no older member of its family, or -1.
  function automatic int model_pick();
    for (int i = 0; i < mq.size(); i++) begin
      bit blocked;
      blocked = 1'b0;
      if (fam(mq[i].ty) != 2) begin
        for (int j = 0; j < i; j++) if (fam(mq[j].ty) == fam(mq[i].ty)) blocked = 1'b1;
      end
      if (mq[i].rdy && !blocked) return i;
    end
    return -1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic iv, input logic [3:0] it, input logic [2:0] ity,
                     input logic rv, input logic [3:0] rt);
    int pk;
    int sz;
    bit load_other;
    @(negedge clk);
    iss_vld = iv; iss_tag = it; iss_ty = ity;
    rdy_vld = rv; rdy_tag = rt;
    #1;
    pk = model_pick();
    // R2: grant validity, tag and type compared every cycle
    check(cur_req, "gnt_vld", int'(gnt_vld), (pk >= 0) ? 1 : 0);
    if (pk >= 0 && gnt_vld) begin
      check(cur_req, "gnt_tag", int'(gnt_tag), int'(mq[pk].tag));
      check(cur_req, "gnt_ty", int'(gnt_ty), int'(mq[pk].ty));
    end
    check("R8", "err_overflow", int'(err_overflow), int'(e_ovf));
    check("R9", "err_order", int'(err_order), int'(e_ord));
    check("R10", "err_type", int'(err_type), int'(e_typ));
    // model update for the coming edge
    sz = mq.size();
    load_other = 1'b0;
    for (int i = 0; i < sz; i++) if (mq[i].ty == 3'd0 && i != pk) load_other = 1'b1;
    e_typ = iv && (ity > 3'd4);
    e_ovf = iv && (ity <= 3'd4) && (sz == DEPTH);
    e_ord = iv && (ity == 3'd1) && (sz < DEPTH) && load_other;
    if (pk >= 0) mq.delete(pk);
    if (rv) for (int i = 0; i < mq.size(); i++) if (mq[i].tag == rt) mq[i].rdy = 1'b1;
    if (iv && (ity <= 3'd4) && (sz < DEPTH)) begin
      ment_t e;
      e.tag = it; e.ty = ity; e.rdy = rv && (rt == it);
      mq.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 4'd0, 3'd0, 1'b0, 4'd0);
  endtask

  task automatic issue(input logic [3:0] t, input logic [2:0] ty);
    cyc(1'b1, t, ty, 1'b0, 4'd0);
  endtask

  task automatic issue_rdy(input logic [3:0] t, input logic [2:0] ty);
    cyc(1'b1, t, ty, 1'b1, t);
  endtask

  task automatic ready(input logic [3:0] t);
    cyc(1'b0, 4'd0, 3'd0, 1'b1, t);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog all-requirements actual=%0d cycles expected<20000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; cycles = 0; done = 1'b0;
    e_ovf = 0; e_ord = 0; e_typ = 0;
    iss_vld = 0; iss_tag = 0; iss_ty = 0; rdy_vld = 0; rdy_tag = 0;
    rst_n = 1'b0;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check("R1", "gnt_vld in reset", int'(gnt_vld), 0);
    check("R1", "errors in reset", int'({err_overflow, err_order, err_type}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R3";   // stores complete in issue order despite reverse ready
    issue(4'd1, 3'd1); issue(4'd2, 3'd1); issue(4'd3, 3'd1);
    ready(4'd3); ready(4'd2); idle(3); ready(4'd1); idle(5);

    cur_req = "R3";   // load waits for older stores; R11 ready at issue
    issue(4'd4, 3'd1); issue(4'd5, 3'd1); issue_rdy(4'd6, 3'd0);
    idle(3); ready(4'd4); ready(4'd5); idle(5);

    cur_req = "R4";   // block store and coherent write in order
    issue(4'd7, 3'd2); issue(4'd8, 3'd3); ready(4'd8); idle(3);
    ready(4'd7); idle(4);

    cur_req = "R5";   // writeback passes an older unready store
    issue(4'd9, 3'd1); issue(4'd10, 3'd4); ready(4'd10); idle(2);
    ready(4'd9); idle(3);

    cur_req = "R6";   // several become eligible at once, oldest first
    issue(4'd1, 3'd2); issue(4'd2, 3'd1); issue_rdy(4'd3, 3'd2); issue_rdy(4'd4, 3'd1);
    ready(4'd1); ready(4'd2); idle(6);

    cur_req = "R7";   // fill to depth, overflow, refill with grant pending
    for (int k = 0; k < DEPTH; k++) issue(4'(k), 3'd4);
    cur_req = "R8";
    issue(4'd8, 3'd4);
    ready(4'd0);
    issue(4'd9, 3'd4);
    issue(4'd10, 3'd4);
    cur_req = "R7";
    for (int k = 1; k < DEPTH; k++) ready(4'(k));
    ready(4'd8); ready(4'd10); idle(4);

    cur_req = "R9";   // store behind held load: flagged, accepted, stays behind
    issue(4'd1, 3'd0); issue(4'd2, 3'd1); ready(4'd2); idle(3);
    ready(4'd1); idle(4);

    cur_req = "R10";  // illegal codes dropped
    issue(4'd3, 3'd5); issue(4'd4, 3'd7); ready(4'd3); ready(4'd4); idle(3);

    cur_req = "R11";  // stray ready has no lasting effect
    ready(4'd12); issue(4'd12, 3'd1); idle(3); ready(4'd12); idle(3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule